// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit

This unit moves an operand by exactly one bit position using one of nine operations: bitwise inversion, logical and arithmetic shifts in both directions, plain rotates in both directions, and rotates through the carry flag. The operand is treated as 8, 16 or 32 bits wide according to a width select. Bits above the selected width are ignored on input and returned as zero.

Alongside the result, the unit produces the four condition flags: negative, zero, overflow and carry. All nine operations share one flag path. The carry input supplies the old carry. Rotate-through-carry operations shift it into the vacated end, and inversion passes it through unchanged.

A request is presented with a valid strobe. Result and flags are registered and appear one cycle later, together with a one-cycle done pulse. They then hold until the next request. Writing the result to a register file is left to the surrounding datapath.

Top module: `shrot_unit`

## Requirements
- R1: Op codes 0 to 4 select inversion (0), logical left shift (1, zero enters bit 0), logical right shift (2, zero enters the top bit), arithmetic left shift (3, same result as 1) and arithmetic right shift (4, the top bit is kept unchanged).
- R2: Op code 5 rotates left, with the top bit entering bit 0. Op code 6 rotates right, with bit 0 entering the top bit.
- R3: Op code 7 rotates left through carry and op code 8 rotates right through carry. The carry input enters the vacated end, and the bit moved out becomes the new carry.
- R4: Width select 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. The top bit is bit 7, 15 or 31. Operand bits above the width are ignored, and result bits above the width are zero.
- R5: Carry becomes the operand's top bit for op codes 1, 3, 5 and 7. It becomes operand bit 0 for op codes 2, 4, 6 and 8. For op code 0 it equals the carry input.
- R6: Overflow is set for op code 3 only, and only when the operand's top bit differs from the bit just below it. Every other op code clears it.
- R7: Negative is the top bit of the result at the selected width. Zero is set exactly when the width-masked result is zero.
- R8: The done output is high for exactly one cycle, the cycle after a cycle with the valid strobe high. Result and flags for that request are presented in the same cycle.
- R9: While the valid strobe is low, result and flags keep their last values, whatever the other inputs do.
- R10: Op codes 9 to 15 return the width-masked operand unchanged, clear overflow and copy the carry input to carry.
- R11: After reset the result is zero, all flags are zero and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one request per high cycle |
| in_op | input | 4 | Operation code (see R1 to R3, R10) |
| in_width | input | 2 | Width select: 0 = 8, 1 = 16, 2/3 = 32 bits |
| in_data | input | 32 | Operand |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Done pulse, one cycle |
| out_data | output | 32 | Result, zero above the selected width |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
Every result and flag of a request is due exactly one clock edge after the edge that sees the valid strobe. The bench drives each request on a falling edge and holds it for one cycle. It then drops the strobe and compares all outputs at the next falling edge, half a cycle after the capturing edge. Hold behaviour is checked two falling edges later, with the strobe low and the other inputs changed. The byte width is swept exhaustively for every operation and both carry values. The wider widths use edge patterns and a pseudo-random sequence, with expected values computed arithmetically.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int LANE_BASE_W = 8;
    localparam int NUM_LANES   = 3;
    localparam int LONG_W      = LANE_BASE_W << (NUM_LANES - 1);
    localparam int WSEL_W      = 2;
    localparam int OP_W        = 4;

    typedef enum logic [OP_W-1:0] {
        OP_INV  = 4'd0,
        OP_LSL  = 4'd1,
        OP_LSR  = 4'd2,
        OP_ASL  = 4'd3,
        OP_ASR  = 4'd4,
        OP_ROL  = 4'd5,
        OP_ROR  = 4'd6,
        OP_RCL  = 4'd7,
        OP_RCR  = 4'd8
    } op_e;

    typedef struct packed {
        logic [LONG_W-1:0] data;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
        logic              done;
    } shrot_state_t;

endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd,
    input  op_e          op,
    input  logic         c_in,
    output logic [W-1:0] res,
    output logic         n_out,
    output logic         z_out,
    output logic         v_out,
    output logic         c_out
);
    localparam int TOP = W - 1;

    logic msb;
    logic lsb;
    logic nxt;

    assign msb = opnd[TOP];
    assign lsb = opnd[0];
    assign nxt = opnd[TOP-1];

    always_comb begin
        res   = opnd;
        c_out = c_in;
        v_out = 1'b0;
        case (op)
            OP_INV: begin
                res = ~opnd;
            end
            OP_LSL: begin
                res   = {opnd[TOP-1:0], 1'b0};
                c_out = msb;
            end
            OP_LSR: begin
                res   = {1'b0, opnd[TOP:1]};
                c_out = lsb;
            end
            OP_ASL: begin
                res   = {opnd[TOP-1:0], 1'b0};
                c_out = msb;
                v_out = msb ^ nxt;
            end
            OP_ASR: begin
                res   = {msb, opnd[TOP:1]};
                c_out = lsb;
            end
            OP_ROL: begin
                res   = {opnd[TOP-1:0], msb};
                c_out = msb;
            end
            OP_ROR: begin
                res   = {lsb, opnd[TOP:1]};
                c_out = lsb;
            end
            OP_RCL: begin
                res   = {opnd[TOP-1:0], c_in};
                c_out = msb;
            end
            OP_RCR: begin
                res   = {c_in, opnd[TOP:1]};
                c_out = lsb;
            end
            default: begin
                res   = opnd;
                c_out = c_in;
            end
        endcase
        n_out = res[TOP];
        z_out = (res == '0);
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [WSEL_W-1:0] in_width,
    input  logic [LONG_W-1:0] in_data,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [LONG_W-1:0] out_data,
    output logic              out_n,
    output logic              out_z,
    output logic              out_v,
    output logic              out_c
);
    localparam logic [WSEL_W-1:0] LAST_SEL = WSEL_W'(NUM_LANES - 1);

    op_e               op_sel;
    logic [LONG_W-1:0] lane_res [NUM_LANES];
    logic              lane_n   [NUM_LANES];
    logic              lane_z   [NUM_LANES];
    logic              lane_v   [NUM_LANES];
    logic              lane_c   [NUM_LANES];
    logic [WSEL_W-1:0] sel;

    shrot_state_t st_d;
    shrot_state_t st_q;

    assign op_sel = op_e'(in_op);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = LANE_BASE_W << g;
        logic [LW-1:0] r_w;

        shrot_lane #(.W(LW)) u_lane (
            .opnd  (in_data[LW-1:0]),
            .op    (op_sel),
            .c_in  (in_carry),
            .res   (r_w),
            .n_out (lane_n[g]),
            .z_out (lane_z[g]),
            .v_out (lane_v[g]),
            .c_out (lane_c[g])
        );

        assign lane_res[g] = LONG_W'(r_w);
    end

    always_comb begin
        sel = (in_width > LAST_SEL) ? LAST_SEL : in_width;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (in_valid) begin
            st_d.data = lane_res[sel];
            st_d.n    = lane_n[sel];
            st_d.z    = lane_z[sel];
            st_d.v    = lane_v[sel];
            st_d.c    = lane_c[sel];
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.done;
    assign out_data  = st_q.data;
    assign out_n     = st_q.n;
    assign out_z     = st_q.z;
    assign out_v     = st_q.v;
    assign out_c     = st_q.c;

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_done_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data) && $stable(out_c) && $stable(out_v));

    p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_width == '0 |=> out_data[LONG_W-1:LANE_BASE_W] == '0);

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_z == (out_data == '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op != OP_W'(OP_ASL) |=> !out_v);

    p_inv_keeps_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op == OP_W'(OP_INV) |=> out_c == $past(in_carry));

    p_rcl_carry_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op == OP_W'(OP_RCL) |=> out_data[0] == $past(in_carry));

endmodule

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [1:0]  in_width;
    logic [31:0] in_data;
    logic        in_carry;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_n, out_z, out_v, out_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shrot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_width(in_width), .in_data(in_data), .in_carry(in_carry),
        .out_valid(out_valid), .out_data(out_data), .out_n(out_n),
        .out_z(out_z), .out_v(out_v), .out_c(out_c)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        if (op <= 4) return "R1";
        if (op <= 6) return "R2";
        if (op <= 8) return "R3";
        return "R10";
    endfunction

    // Arithmetic model of the requirements
    task automatic model(input int op, input int wcode, input logic [31:0] d,
                         input logic cin, output logic [31:0] r,
                         output logic n, output logic z, output logic v,
                         output logic c);
        int w;
        logic [63:0] mask, x, top, nxt, b0, rr;
        w    = (wcode == 0) ? 8 : (wcode == 1) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        x    = {32'd0, d} & mask;
        top  = (x >> (w - 1)) & 64'd1;
        nxt  = (x >> (w - 2)) & 64'd1;
        b0   = x & 64'd1;
        v    = 1'b0;
        c    = cin;
        case (op)
            0: rr = ~x & mask;
            1: begin rr = (x << 1) & mask; c = top[0]; end
            2: begin rr = x >> 1; c = b0[0]; end
            3: begin rr = (x << 1) & mask; c = top[0]; v = top[0] ^ nxt[0]; end
            4: begin rr = (x >> 1) | (top << (w - 1)); c = b0[0]; end
            5: begin rr = ((x << 1) | top) & mask; c = top[0]; end
            6: begin rr = (x >> 1) | (b0 << (w - 1)); c = b0[0]; end
            7: begin rr = ((x << 1) | {63'd0, cin}) & mask; c = top[0]; end
            8: begin rr = (x >> 1) | ({63'd0, cin} << (w - 1)); c = b0[0]; end
            default: rr = x;
        endcase
        r = rr[31:0];
        n = rr[w-1];
        z = (rr == 64'd0);
    endtask

    task automatic run(input int op, input int wcode, input logic [31:0] d,
                       input logic cin);
        logic [31:0] er;
        logic en, ez, ev, ec;
        int w;
        string tg;
        w  = (wcode == 0) ? 8 : (wcode == 1) ? 16 : 32;
        tg = op_tag(op);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op[3:0];
        in_width = wcode[1:0];
        in_data  = d;
        in_carry = cin;
        @(negedge clk);
        in_valid = 1'b0;
        model(op, wcode, d, cin, er, en, ez, ev, ec);
        chk(tg, "result", {32'd0, out_data}, {32'd0, er});
        if (w < 32) chk("R4", "bits above width", {32'd0, out_data >> w}, 64'd0);
        chk((op == 0 || op > 8) ? ((op == 0) ? "R5" : "R10") : "R5", "carry",
            {63'd0, out_c}, {63'd0, ec});
        chk("R6", "overflow", {63'd0, out_v}, {63'd0, ev});
        chk("R7", "negative", {63'd0, out_n}, {63'd0, en});
        chk("R7", "zero", {63'd0, out_z}, {63'd0, ez});
        chk("R8", "done pulse", {63'd0, out_valid}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] held;
        logic        held_c, held_v, held_n, held_z;
        logic [31:0] corners [6];
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_op    = 4'd0;
        in_width = 2'd0;
        in_data  = 32'd0;
        in_carry = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "reset data", {32'd0, out_data}, 64'd0);
        chk("R11", "reset flags", {60'd0, out_n, out_z, out_v, out_c}, 64'd0);
        chk("R11", "reset done", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "idle done low", {63'd0, out_valid}, 64'd0);

        // Exhaustive byte sweep with noise above the byte (R4)
        for (int op = 0; op < 9; op++)
            for (int ci = 0; ci < 2; ci++)
                for (int b = 0; b < 256; b++)
                    run(op, 0, {24'hC3A55A ^ 24'(b * 7), b[7:0]}, ci[0]);

        // Wider widths, all op codes including undefined ones
        corners[0] = 32'h0000_0000;
        corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h8000_8000;
        corners[3] = 32'h4000_4000;
        corners[4] = 32'h0000_0001;
        corners[5] = 32'hC000_C001;
        lfsr = 32'hACE1_2468;
        for (int op = 0; op < 16; op++)
            for (int wc = 0; wc < 4; wc++)
                for (int ci = 0; ci < 2; ci++) begin
                    for (int k = 0; k < 6; k++) run(op, wc, corners[k], ci[0]);
                    for (int k = 0; k < 24; k++) begin
                        lfsr = lfsr ^ (lfsr << 13);
                        lfsr = lfsr ^ (lfsr >> 17);
                        lfsr = lfsr ^ (lfsr << 5);
                        run(op, wc, lfsr, ci[0]);
                    end
                end

        // R9: outputs hold while the strobe is low
        run(5, 2, 32'h8765_4321, 1'b1);
        held   = out_data;
        held_c = out_c;
        held_v = out_v;
        held_n = out_n;
        held_z = out_z;
        in_op    = 4'd3;
        in_data  = 32'h4000_0000;
        in_carry = 1'b0;
        in_width = 2'd0;
        repeat (2) @(negedge clk);
        chk("R9", "held data", {32'd0, out_data}, {32'd0, held});
        chk("R9", "held flags", {60'd0, out_n, out_z, out_v, out_c},
            {60'd0, held_n, held_z, held_v, held_c});
        chk("R8", "done single cycle", {63'd0, out_valid}, 64'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule